// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter of parameterised width (four bits by default). It counts in plain binary and rolls over from its all-ones value back to zero. On a rising clock edge it can instead take a new value from its data inputs. Two count enables must both be high for it to advance. Only the second of them, the trickle enable, feeds the carry output. Because of this, several stages can be chained into one wider synchronous counter or a programmable divider. A slow-settling parallel enable never ripples along the chain.

The reset style is set when the block is built. In the asynchronous build, a low reset clears the count at once, with no clock needed. In the synchronous build, a low reset clears the count at the next rising edge and wins over both load and count.

Top module: `presettable_counter`

## Requirements
- R1: With the reset high, load_n high and both en_par and en_trk high, q advances by one on each rising clock edge and wraps from all ones (15 at the default width) to 0.
- R2: With the reset high and load_n low, q takes the value of din on the rising edge, whatever the enables are doing.
- R3: With the reset high, load_n high and either enable low, q keeps its value across the edge.
- R4: carry_out is high exactly when en_trk is high and q is all ones. en_par has no influence on carry_out.
- R5: In the asynchronous build (RST_STYLE = RST_ASYNC), a low rst_n clears q to 0 without waiting for a clock edge. It keeps q at 0 for as long as it stays low, whatever load_n and the enables are doing.
- R6: In the synchronous build (RST_STYLE = RST_SYNC), a low rst_n leaves q unchanged until the next rising edge and clears it to 0 on that edge, even when load_n is low and both enables are high.
- R7: Two stages can form one wider counter. Both stages share the enable. The upper stage's en_trk comes from the lower stage's carry_out. The pair then counts from 0 to 255 and wraps, and the upper carry is high only at 255 with the enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, does not affect carry |
| en_trk | input | 1 | Trickle count enable, also gates carry_out |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count flag for chaining stages |

## Verification
The hardest situations to reach from the ports are those where the reset arrives away from a clock edge. The stimulus loads a nonzero value into a two-stage chain and drops the reset a fraction of a period after an edge. It then samples well before the next edge to see the asynchronous clear. In the synchronous build, reset, load and both enables are asserted together between edges. The count is checked both before and after the edge, which shows that the clear waits for the edge and outranks the load. The two enables are also split at the all-ones count, one at a time, to show that only the trickle enable moves the carry.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic {
    RST_ASYNC = 1'b0,
    RST_SYNC  = 1'b1
  } rst_style_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/pcnt_next.sv
module pcnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] q_nxt,
  output logic             upd
);

  cnt_op_e op;

  // Priority below the clear: load, then count, then hold.
  always_comb begin
    if (!load_n)
      op = OP_LOAD;
    else if (en_par && en_trk)
      op = OP_INC;
    else
      op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_LOAD: q_nxt = din;
      OP_INC:  q_nxt = q + WIDTH'(1);
      default: q_nxt = q;
    endcase
  end

  assign upd = (op != OP_HOLD);

endmodule

// File: rtl/pcnt_reg.sv
module pcnt_reg
  import cnt_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter rst_style_e RST_STYLE = RST_ASYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [WIDTH-1:0] q_nxt,
  output logic [WIDTH-1:0] q
);

  generate
    if (RST_STYLE == RST_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (upd)
          q <= q_nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (upd)
          q <= q_nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/pcnt_term.sv
module pcnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             carry_out
);

  logic at_top;

  assign at_top    = &q;
  assign carry_out = en_trk & at_top;

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter rst_style_e RST_STYLE = RST_ASYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  logic [WIDTH-1:0] q_nxt;
  logic             upd;

  pcnt_next #(.WIDTH(WIDTH)) next_i (
    .q      (q),
    .din    (din),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .q_nxt  (q_nxt),
    .upd    (upd)
  );

  pcnt_reg #(.WIDTH(WIDTH), .RST_STYLE(RST_STYLE)) reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .q_nxt (q_nxt),
    .q     (q)
  );

  pcnt_term #(.WIDTH(WIDTH)) term_i (
    .q         (q),
    .en_trk    (en_trk),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk
  import cnt_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter rst_style_e RST_STYLE = RST_ASYNC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk) |=> (q == WIDTH'($past(q) + WIDTH'(1))));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n) |=> (q == $past(din)));

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));

  // R4
  carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_trk && (q == {WIDTH{1'b1}})));

  generate
    if (RST_STYLE == RST_ASYNC) begin : g_async_chk
      // R5
      async_clear_chk: assert property (@(posedge clk)
        (!rst_n) |-> (q == '0));
    end else begin : g_sync_chk
      // R6
      sync_clear_chk: assert property (@(posedge clk)
        (!rst_n) |=> (q == '0));
    end
  endgenerate

endmodule

bind presettable_counter presettable_counter_chk #(
  .WIDTH     (WIDTH),
  .RST_STYLE (RST_STYLE)
) chk_i (.*);

// File: tb/presettable_counter_tb_top.sv
`timescale 1ns/1ps
module presettable_counter_tb_top;
  import cnt_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // Cascade of two asynchronous-reset stages (dut_i is the low stage)
  logic       arst_n, c_load_n, c_en;
  logic [7:0] c_din;
  logic [3:0] q_lo, q_hi;
  logic       cy_lo, cy_hi;

  presettable_counter #(.WIDTH(4), .RST_STYLE(RST_ASYNC)) dut_i (
    .clk(clk), .rst_n(arst_n), .load_n(c_load_n), .en_par(c_en), .en_trk(c_en),
    .din(c_din[3:0]), .q(q_lo), .carry_out(cy_lo));

  presettable_counter #(.WIDTH(4), .RST_STYLE(RST_ASYNC)) dut_hi_i (
    .clk(clk), .rst_n(arst_n), .load_n(c_load_n), .en_par(c_en), .en_trk(cy_lo),
    .din(c_din[7:4]), .q(q_hi), .carry_out(cy_hi));

  // Single synchronous-reset stage
  logic       srst_n, s_load_n, s_ep, s_et;
  logic [3:0] s_din, s_q;
  logic       s_cy;

  presettable_counter #(.WIDTH(4), .RST_STYLE(RST_SYNC)) dut_s_i (
    .clk(clk), .rst_n(srst_n), .load_n(s_load_n), .en_par(s_ep), .en_trk(s_et),
    .din(s_din), .q(s_q), .carry_out(s_cy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {load_n, en, din[7:0], expected q[7:0], expected upper carry}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hFD, 8'hFD, 1'b0},  // R2 load
    {1'b1, 1'b1, 8'h00, 8'hFE, 1'b0},  // R1
    {1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},  // R7 carry at 255
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R7 wrap
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R3 hold
    {1'b0, 1'b1, 8'h3E, 8'h3E, 1'b0},  // R2 load beats count
    {1'b1, 1'b1, 8'h00, 8'h3F, 1'b0},  // R1
    {1'b1, 1'b1, 8'h00, 8'h40, 1'b0},  // R7 nibble carry
    {1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0},  // R4 no carry, enable low
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0}   // R1 wrap
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; c_load_n = 1'b1; c_en = 1'b1; c_din = 8'h00;
    srst_n = 1'b0; s_load_n = 1'b1; s_ep = 1'b1; s_et = 1'b1; s_din = 4'h0;
    repeat (3) step();
    chk("R5 reset q", {q_hi, q_lo}, 8'h00);
    chk("R5 reset carry", cy_hi, 1'b0);
    chk("R6 reset q", s_q, 4'h0);
    arst_n = 1'b1; srst_n = 1'b1; c_en = 1'b0; s_ep = 1'b0; s_et = 1'b0;

    for (int i = 0; i < NV; i++) begin
      c_load_n = VEC[i][18];
      c_en     = VEC[i][17];
      c_din    = VEC[i][16:9];
      step();
      chk($sformatf("R7 vec%0d q", i), {q_hi, q_lo}, VEC[i][8:1]);
      chk($sformatf("R7 vec%0d carry", i), cy_hi, VEC[i][0]);
    end

    // R5: clear between edges
    c_load_n = 1'b0; c_en = 1'b1; c_din = 8'h5A;
    step();
    chk("R2 load 5A", {q_hi, q_lo}, 8'h5A);
    c_load_n = 1'b1;
    #0.5 arst_n = 1'b0;
    #0.5;
    chk("R5 immediate clear", {q_hi, q_lo}, 8'h00);
    c_load_n = 1'b0;
    step();
    chk("R5 clear holds over load", {q_hi, q_lo}, 8'h00);
    arst_n = 1'b1; c_load_n = 1'b1;
    step();
    chk("R1 count after release", {q_hi, q_lo}, 8'h01);

    // R6: synchronous clear waits for the edge and beats load
    s_load_n = 1'b0; s_din = 4'h9;
    step();
    chk("R2 sync stage load", s_q, 4'h9);
    srst_n = 1'b0; s_din = 4'h7; s_ep = 1'b1; s_et = 1'b1;
    #0.5;
    chk("R6 no clear before edge", s_q, 4'h9);
    step();
    chk("R6 clear at edge", s_q, 4'h0);
    srst_n = 1'b1; s_din = 4'hF;
    step();
    chk("R2 load F", s_q, 4'hF);

    // R4 / R3: split enables at all ones
    s_load_n = 1'b1; s_ep = 1'b0; s_et = 1'b1;
    #0.5;
    chk("R4 carry with en_par low", s_cy, 1'b1);
    step();
    chk("R3 hold en_par low", s_q, 4'hF);
    s_ep = 1'b1; s_et = 1'b0;
    #0.5;
    chk("R4 carry with en_trk low", s_cy, 1'b0);
    step();
    chk("R3 hold en_trk low", s_q, 4'hF);
    s_et = 1'b1;
    #0.5;
    chk("R4 carry both high", s_cy, 1'b1);
    step();
    chk("R1 wrap 15 to 0", s_q, 4'h0);
    chk("R4 carry after wrap", s_cy, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule